// File: doc/BRIEF.md
# Network Controller Interrupt Moderator

This block sits between the receive and transmit paths of a network controller and the host's single interrupt line. Causes can arrive in two ways. They come from a generic post port, which carries an optional "urgent" flag. They also come from four internal delay timers. A cause sets a bit in a pending register, and an enable mask selects which pending bits may drive the line. A throttle timer limits how often the line can rise. An urgent post whose cause is enabled skips the throttle.

The four delay timers are a receive packet timer, a receive absolute timer, a transmit packet timer and a transmit absolute timer. A packet timer starts again on every new packet event. An absolute timer starts only on the first event while it is idle, so it caps the latency seen by the first packet. When a receive timer expires, the block raises a receive writeback request to the descriptor logic and posts the receive-timer cause. When a transmit timer expires, it raises a transmit writeback request and posts the transmit-done cause. A writeback request stays high until the descriptor logic acknowledges it.

Timer values count in units of 1024 ns. The unit is derived from the clock by a prescaler of `PRESCALE` clocks. A small register port gives access to the cause, mask, delay and throttle values.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset, `irq`, `rx_wb_req` and `tx_wb_req` are low, and reading the mask at address 1 returns 0.
- R2: Register addresses are: 0 cause, 1 mask, 2 receive packet delay, 3 receive absolute delay, 4 transmit packet delay, 5 transmit absolute delay, 6 throttle. A post sets its bits in the pending register. Reading address 0 returns the pending bits and clears them. With the throttle at zero, `irq` is high from the clock edge that latches the post exactly when pending AND mask is nonzero.
- R3: A write to the mask re-evaluates the pending bits on that edge. The write can raise `irq` or drop it.
- R4: Each rise of `irq` loads the throttle counter with the throttle value, in units. While the counter is nonzero, a non-urgent post only sets pending bits. Once the counter runs out, `irq` rises if an enabled cause is pending.
- R5: An urgent post (`post_now`) whose cause is enabled raises `irq` on the next edge, even while the throttle counter is running. An urgent post whose cause is masked does not raise `irq`, but its bit is still pending.
- R6: One unit is `PRESCALE` clocks. A receive timer loaded with N expires N units after it is loaded, within one unit. At expiry it sets `rx_wb_req` and pending bit 1.
- R7: A new `rx_pkt_evt` or `tx_pkt_evt` restarts the matching packet delay timer.
- R8: A new packet event does not restart an absolute delay timer that is already running.
- R9: When either transmit timer expires, it sets `tx_wb_req` and pending bit 0.
- R10: A delay register that holds zero disables its timer, so a packet event then causes no expiry.
- R11: `rx_wb_req` and `tx_wb_req` stay high until their own acknowledge. Then they drop on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pkt_evt | input | 1 | One-cycle pulse per received packet |
| tx_pkt_evt | input | 1 | One-cycle pulse per transmitted descriptor |
| post_vld | input | 1 | Generic cause post strobe |
| post_cause | input | CW | Cause bits to post |
| post_now | input | 1 | Urgent post that bypasses the throttle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears cause on address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | TW | Register write data |
| reg_rdata | output | TW | Register read data (combinational) |
| irq | output | 1 | Interrupt line to the host |
| rx_wb_req | output | 1 | Receive descriptor writeback request |
| rx_wb_ack | input | 1 | Receive writeback acknowledge |
| tx_wb_req | output | 1 | Transmit descriptor writeback request |
| tx_wb_ack | input | 1 | Transmit writeback acknowledge |

## Verification
A table of mask and cause pairs exercises the line. The pairs include overlapping, disjoint, single-bit, full and empty patterns. They show whether `irq` follows the AND of pending and mask, rather than either term alone, and whether a read clears exactly the posted bits. Each timer test sends one or two packet events and measures the delay to the writeback request against bounds derived from `PRESCALE`. A second event part-way through a countdown separates the restarting packet timer from the non-restarting absolute timer. The throttle tests set a non-urgent post, an urgent enabled post and an urgent masked post against a running throttle counter. They show whether the bypass follows the mask.

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator #(
  parameter int CW       = 8,
  parameter int TW       = 16,
  parameter int PRESCALE = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_pkt_evt,
  input  logic          tx_pkt_evt,
  input  logic          post_vld,
  input  logic [CW-1:0] post_cause,
  input  logic          post_now,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] reg_rdata,
  output logic          irq,
  output logic          rx_wb_req,
  input  logic          rx_wb_ack,
  output logic          tx_wb_req,
  input  logic          tx_wb_ack
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int NT = 4;

  logic [PW-1:0] pre_q;
  logic          tick;
  assign tick = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk)
    if (!rst_n || tick) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;

  logic [CW-1:0] mask_q, pend_q;
  logic [TW-1:0] thr_q, thr_cnt_q;
  logic [TW-1:0] dly_q [NT];
  logic [TW-1:0] cnt_q [NT];
  logic [NT-1:0] evt, expire;

  assign evt = {tx_pkt_evt, tx_pkt_evt, rx_pkt_evt, rx_pkt_evt};

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam bit ABS = (i % 2) == 1;
    logic wr_sel, start;
    assign wr_sel    = reg_wr && (reg_addr == 3'(i + 2));
    assign start     = evt[i] && (!ABS || cnt_q[i] == '0);
    assign expire[i] = tick && (cnt_q[i] == TW'(1));

    always_ff @(posedge clk)
      if (!rst_n)      dly_q[i] <= '0;
      else if (wr_sel) dly_q[i] <= reg_wdata;

    always_ff @(posedge clk)
      if (!rst_n || dly_q[i] == '0)  cnt_q[i] <= '0;
      else if (start)                cnt_q[i] <= dly_q[i];
      else if (tick && cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - 1'b1;

    // R10
    dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_q[i] == '0) |=> (cnt_q[i] == '0));
  end

  logic          rx_exp, tx_exp, rd_cause, wr_mask, now_hit, fire, live;
  logic [CW-1:0] post_bits, pend_nx, mask_nx;

  assign rx_exp    = expire[0] | expire[1];
  assign tx_exp    = expire[2] | expire[3];
  assign rd_cause  = reg_rd && reg_addr == 3'd0;
  assign wr_mask   = reg_wr && reg_addr == 3'd1;
  assign post_bits = (post_vld ? post_cause : '0) | CW'({rx_exp, tx_exp});
  assign pend_nx   = (rd_cause ? '0 : pend_q) | post_bits;
  assign mask_nx   = wr_mask ? reg_wdata[CW-1:0] : mask_q;
  assign live      = |(pend_nx & mask_nx);
  assign now_hit   = post_vld && post_now && |(post_cause & mask_nx);
  assign fire      = live && !irq && (thr_cnt_q == '0 || now_hit);

  always_ff @(posedge clk)
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      thr_q  <= '0;
    end else begin
      pend_q <= pend_nx;
      mask_q <= mask_nx;
      if (reg_wr && reg_addr == 3'd6) thr_q <= reg_wdata;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      irq       <= 1'b0;
      thr_cnt_q <= '0;
    end else begin
      irq <= live && (irq || fire);
      if (fire)                         thr_cnt_q <= thr_q;
      else if (tick && thr_cnt_q != '0) thr_cnt_q <= thr_cnt_q - 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_wb_req <= 1'b0;
      tx_wb_req <= 1'b0;
    end else begin
      rx_wb_req <= rx_exp | (rx_wb_req & ~rx_wb_ack);
      tx_wb_req <= tx_exp | (tx_wb_req & ~tx_wb_ack);
    end

  always_comb
    case (reg_addr)
      3'd0:    reg_rdata = TW'(pend_q);
      3'd1:    reg_rdata = TW'(mask_q);
      3'd2, 3'd3, 3'd4, 3'd5:
               reg_rdata = dly_q[2'(reg_addr - 3'd2)];
      3'd6:    reg_rdata = thr_q;
      default: reg_rdata = '0;
    endcase

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(pend_q & mask_q));
  // R4
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(thr_cnt_q) == '0 || $past(now_hit)));
  // R6
  rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_wb_req) |-> pend_q[1]);
  // R9
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_wb_req) |-> pend_q[0]);
  // R11
  rx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wb_req && !rx_wb_ack) |=> rx_wb_req);
  // R11
  tx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wb_req && !tx_wb_ack) |=> tx_wb_req);
endmodule

// File: tb/nic_irq_moderator_tb.sv
module nic_irq_moderator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 4;
  localparam int CW = 8;
  localparam int TW = 16;

  logic clk = 0, rst_n = 0;
  logic rx_pkt_evt = 0, tx_pkt_evt = 0, post_vld = 0, post_now = 0;
  logic [CW-1:0] post_cause = '0;
  logic reg_wr = 0, reg_rd = 0, rx_wb_ack = 0, tx_wb_ack = 0;
  logic [2:0] reg_addr = '0;
  logic [TW-1:0] reg_wdata = '0, reg_rdata;
  logic irq, rx_wb_req, tx_wb_req;

  int checks = 0, bad = 0, k;
  logic [TW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_irq_moderator #(.CW(CW), .TW(TW), .PRESCALE(P)) dut_i (.*);

  localparam logic [15:0] VEC [6] = '{16'hFF01, 16'h0F30, 16'h8181, 16'h0000,
                                      16'h00FF, 16'h2424};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [TW-1:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic post(input logic [CW-1:0] c, input bit now);
    post_vld = 1; post_cause = c; post_now = now;
    @(negedge clk); post_vld = 0; post_now = 0;
  endtask

  task automatic ack(input bit tx);
    if (tx) tx_wb_ack = 1; else rx_wb_ack = 1;
    @(negedge clk); tx_wb_ack = 0; rx_wb_ack = 0;
  endtask

  // pulse an event, optionally again at cycle 'again'; return cycles until request
  task automatic run_tmr(input bit tx, input int again, input int lim, output int cyc);
    if (tx) tx_pkt_evt = 1; else rx_pkt_evt = 1;
    cyc = lim;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      tx_pkt_evt = 0; rx_pkt_evt = 0;
      if ((tx ? tx_wb_req : rx_wb_req)) begin cyc = i; break; end
      if (i == again) begin if (tx) tx_pkt_evt = 1; else rx_pkt_evt = 1; end
    end
    tx_pkt_evt = 0; rx_pkt_evt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; checks++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(3'd1, rv);
    chk(!irq && !rx_wb_req && !tx_wb_req && rv == 0, "R1 reset state", rv, 0);

    // R2 table walk, throttle zero
    foreach (VEC[i]) begin
      logic [7:0] m, c;
      m = VEC[i][15:8]; c = VEC[i][7:0];
      rd(3'd0, rv);
      wr(3'd1, TW'(m));
      post(c, 0);
      chk(irq == |(m & c), "R2 irq follows pending&mask", irq, |(m & c));
      rd(3'd0, rv);
      chk(rv == TW'(c), "R2 cause read value", rv, c);
      chk(irq == 0, "R2 read clears line", irq, 0);
    end

    // R3 mask re-evaluation
    wr(3'd1, 0);
    post(8'h20, 0);
    chk(irq == 0, "R3 masked post", irq, 0);
    wr(3'd1, 16'h20);
    chk(irq == 1, "R3 mask write raises", irq, 1);
    wr(3'd1, 16'h00);
    chk(irq == 0, "R3 mask write drops", irq, 0);
    rd(3'd0, rv);
    chk(rv == 16'h20, "R3 pending kept", rv, 16'h20);

    // R4 throttle
    wr(3'd6, 3);
    wr(3'd1, 16'hFF);
    post(8'h04, 0);
    chk(irq == 1, "R4 first post with idle throttle", irq, 1);
    rd(3'd0, rv);
    post(8'h08, 0);
    chk(irq == 0, "R4 post held by throttle", irq, 0);
    k = 40;
    for (int i = 1; i <= 40; i++) begin
      if (irq) begin k = i; break; end
      @(negedge clk);
    end
    chk(k >= 2 && k <= 3 * P + 2, "R4 assert at throttle expiry", k, 3 * P);

    // R5 urgent bypass
    rd(3'd0, rv);
    post(8'h10, 1);
    chk(irq == 1, "R5 urgent bypass", irq, 1);
    rd(3'd0, rv);
    wr(3'd1, 16'h01);
    post(8'h10, 1);
    chk(irq == 0, "R5 masked urgent stays low", irq, 0);
    rd(3'd0, rv);
    chk(rv == 16'h10, "R5 masked urgent pending", rv, 16'h10);
    wr(3'd6, 0);
    wr(3'd1, 16'h03);

    // R6 receive packet timer
    wr(3'd2, 5);
    run_tmr(0, 0, 100, k);
    chk(k >= 4 * P && k <= 5 * P + 2, "R6 rx packet delay", k, 5 * P);
    chk(irq == 1, "R6 rx cause raises line", irq, 1);
    repeat (5) @(negedge clk);
    // R11
    chk(rx_wb_req == 1, "R11 rx request held", rx_wb_req, 1);
    ack(0);
    chk(rx_wb_req == 0, "R11 rx request dropped by ack", rx_wb_req, 0);
    rd(3'd0, rv);
    chk(rv == 16'h02, "R6 rx cause bit", rv, 2);

    // R7 restart
    run_tmr(0, 12, 100, k);
    chk(k >= 12 + 4 * P && k <= 12 + 5 * P + 2, "R7 packet timer restarted", k, 12 + 5 * P);
    ack(0); rd(3'd0, rv);

    // R8 absolute not restarted
    wr(3'd2, 0);
    wr(3'd3, 6);
    run_tmr(0, 12, 100, k);
    chk(k >= 5 * P && k <= 6 * P + 2, "R8 absolute timer kept", k, 6 * P);
    ack(0); rd(3'd0, rv);

    // R10 disabled
    wr(3'd3, 0);
    run_tmr(0, 0, 80, k);
    chk(k == 80 && !irq, "R10 rx disabled no expiry", k, 80);
    run_tmr(1, 0, 80, k);
    chk(k == 80 && !irq, "R10 tx disabled no expiry", k, 80);

    // R9 transmit timers
    wr(3'd4, 2);
    run_tmr(1, 0, 100, k);
    chk(k >= P && k <= 2 * P + 2, "R9 tx packet delay", k, 2 * P);
    ack(1);
    chk(tx_wb_req == 0, "R11 tx ack", tx_wb_req, 0);
    rd(3'd0, rv);
    chk(rv == 16'h01, "R9 tx cause bit", rv, 1);
    wr(3'd4, 0);
    wr(3'd5, 3);
    run_tmr(1, 4, 100, k);
    chk(k >= 2 * P && k <= 3 * P + 2, "R9 tx absolute delay", k, 3 * P);
    ack(1); rd(3'd0, rv);
    chk(rv == 16'h01, "R9 tx absolute cause", rv, 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule